// File: doc/BRIEF.md
# Byte-Stream Packet Framer and Deframer

This block converts between a header-plus-payload interface and a framed byte stream on a point-to-point readout link. The framer side takes one header (packet type, 32-bit address, payload length). It emits a two-byte alignment marker, then an identifier byte, the address, the length, the payload bytes and a 16-bit CRC. While it emits the frame it draws the payload bytes from a separate byte input.

The deframer side watches an incoming byte stream for the alignment marker. It validates the identifier byte, captures the address and length, and passes the payload straight through to a byte output, marking the last byte. At the end of the frame it compares the received CRC with its own and pulses a done strobe with a pass/fail flag. A malformed identifier makes it drop the frame and resume searching for the marker.

Each stream uses valid/ready handshaking. Both halves share one clock and reset but work independently, so a loopback or two separate links can be wired outside.

Top module: `pkt_framer`

## Requirements
- R1: The framer emits, in order: 0xAA, 0x55, the identifier byte, the address most significant byte first (4 bytes), the length big-endian (2 bytes), the payload bytes, then the CRC high byte followed by the low byte.
- R2: The identifier byte is {type, ~type}, with the type in bits 7:4 and its bitwise complement in bits 3:0. Type 1 is start-of-frame and type 2 is data. A start-of-frame packet always carries length 0 and no payload, whatever header length is given.
- R3: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, data fed MSB first, with no reflection and no final XOR. It covers the address, length and payload bytes. It excludes the alignment marker and the identifier.
- R4: hdr_ready is high only while the framer is idle. It falls on the cycle after a header is accepted and rises again only after the second CRC byte has been transferred.
- R5: A framer output byte held with tx_valid high and tx_ready low stays unchanged. Payload bytes move from pl_data to tx_data with pl_ready equal to tx_ready during the payload phase.
- R6: The deframer finds the 0xAA, 0x55 pair at any byte offset, including after repeated 0xAA bytes. Marker values inside a frame's body do not restart alignment.
- R7: An identifier whose low nibble is not the complement of its high nibble, or whose type is neither 1 nor 2, produces a one-cycle pid_err pulse. The deframer then returns to marker search with no payload output and no done pulse.
- R8: The deframer presents rx_type, rx_addr and rx_len for the frame. It outputs exactly rx_len payload bytes, with out_last high on the final one only. A zero length gives no payload output.
- R9: done pulses for one cycle, in the cycle after the second CRC byte is accepted. crc_ok is high with it exactly when the received CRC equals the CRC computed over the received address, length and payload.
- R10: During the payload phase rx_ready follows out_ready, so stalling the payload output stalls the incoming stream. In every other phase rx_ready is high.
- R11: After reset hdr_ready is 1 and tx_valid, out_valid, done and pid_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header offered to the framer |
| hdr_ready | output | 1 | Framer idle and accepting a header |
| hdr_type | input | 4 | Packet type (1 start-of-frame, 2 data) |
| hdr_addr | input | 32 | Packet address |
| hdr_len | input | 16 | Payload byte count |
| pl_valid | input | 1 | Payload byte offered |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| tx_valid | output | 1 | Framed byte valid |
| tx_ready | input | 1 | Link accepts framed byte |
| tx_data | output | 8 | Framed byte |
| rx_valid | input | 1 | Incoming link byte valid |
| rx_ready | output | 1 | Deframer accepts link byte |
| rx_data | input | 8 | Incoming link byte |
| out_valid | output | 1 | Payload byte out valid |
| out_ready | input | 1 | Payload consumer ready |
| out_data | output | 8 | Payload byte out |
| out_last | output | 1 | Final payload byte of the frame |
| rx_type | output | 4 | Received packet type |
| rx_addr | output | 32 | Received address |
| rx_len | output | 16 | Received payload length |
| done | output | 1 | One-cycle end-of-frame strobe |
| crc_ok | output | 1 | CRC matched, valid with done |
| pid_err | output | 1 | One-cycle identifier rejection strobe |

## Verification
A wrong framer state appears at once in the outgoing byte order or in a misplaced return of hdr_ready. A wrong CRC register appears only at the last two bytes of the frame, so every vector compares the whole emitted stream against a CRC that the bench computes itself. On the deframer, a wrong byte count or phase shows up as a missing or extra out_last or as a stalled done, within the length of one frame. A wrong hunt state shows up as a lost frame after leading junk or after a rejected identifier. The CRC-corruption cases check that a flipped address or CRC byte shows up as crc_ok low on the very done pulse of that frame.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam logic [7:0]  MARK_A    = 8'hAA;
  localparam logic [7:0]  MARK_B    = 8'h55;
  localparam logic [3:0]  KIND_SOF  = 4'h1;
  localparam logic [3:0]  KIND_DATA = 4'h2;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;

  typedef enum logic [2:0] {
    E_IDLE, E_MK0, E_MK1, E_PID, E_ADDR, E_LEN, E_PAY, E_CRC
  } enc_st_t;

  typedef enum logic [2:0] {
    D_HUNT, D_MK1, D_PID, D_ADDR, D_LEN, D_PAY, D_CRC
  } dec_st_t;

  // One byte through the CRC register, MSB first.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [7:0] pid_pack(input logic [3:0] kind);
    return {kind, ~kind};
  endfunction

  function automatic logic pid_good(input logic [7:0] b);
    return (b[3:0] == ~b[7:4]) && ((b[7:4] == KIND_SOF) || (b[7:4] == KIND_DATA));
  endfunction

endpackage

// File: rtl/pf_encoder.sv
module pf_encoder
  import pf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [3:0]        hdr_type,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [7:0]        pl_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int LEN_BYTES  = LEN_W / 8;
  localparam int SH_W       = ADDR_W + LEN_W;

  enc_st_t          st;
  logic [3:0]       kind_q;
  logic [SH_W-1:0]  sh_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt;
  logic [15:0]      crc_q;

  // named events
  logic enc_hdr_take, enc_xfer, enc_covered, enc_pkt_end;

  assign hdr_ready    = (st == E_IDLE);
  assign enc_hdr_take = hdr_valid && hdr_ready;
  assign tx_valid     = (st == E_PAY) ? pl_valid : (st != E_IDLE);
  assign pl_ready     = (st == E_PAY) && tx_ready;
  assign enc_xfer     = tx_valid && tx_ready;
  assign enc_covered  = enc_xfer && (st == E_ADDR || st == E_LEN || st == E_PAY);
  assign enc_pkt_end  = enc_xfer && (st == E_CRC) && (cnt != '0);

  always_comb begin
    case (st)
      E_MK0:         tx_data = MARK_A;
      E_MK1:         tx_data = MARK_B;
      E_PID:         tx_data = pid_pack(kind_q);
      E_ADDR, E_LEN: tx_data = sh_q[SH_W-1 -: 8];
      E_PAY:         tx_data = pl_data;
      E_CRC:         tx_data = (cnt == '0) ? crc_q[15:8] : crc_q[7:0];
      default:       tx_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      kind_q <= '0;
      sh_q   <= '0;
      len_q  <= '0;
      cnt    <= '0;
      crc_q  <= CRC_SEED;
    end else begin
      if (enc_covered) crc_q <= crc_step(crc_q, tx_data);
      if (enc_hdr_take) begin
        kind_q <= hdr_type;
        len_q  <= (hdr_type == KIND_SOF) ? '0 : hdr_len;
        sh_q   <= {hdr_addr, ((hdr_type == KIND_SOF) ? {LEN_W{1'b0}} : hdr_len)};
        crc_q  <= CRC_SEED;
        cnt    <= '0;
        st     <= E_MK0;
      end else if (enc_xfer) begin
        case (st)
          E_MK0: st <= E_MK1;
          E_MK1: st <= E_PID;
          E_PID: begin st <= E_ADDR; cnt <= '0; end
          E_ADDR: begin
            sh_q <= {sh_q[SH_W-9:0], 8'h00};
            if (cnt == LEN_W'(ADDR_BYTES - 1)) begin st <= E_LEN; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          E_LEN: begin
            sh_q <= {sh_q[SH_W-9:0], 8'h00};
            if (cnt == LEN_W'(LEN_BYTES - 1)) begin
              cnt <= '0;
              st  <= (len_q == '0) ? E_CRC : E_PAY;
            end else cnt <= cnt + 1'b1;
          end
          E_PAY: begin
            if (cnt == len_q - 1'b1) begin st <= E_CRC; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          E_CRC: begin
            if (cnt == '0) cnt <= LEN_W'(1);
            else begin st <= E_IDLE; cnt <= '0; end
          end
          default: st <= E_IDLE;
        endcase
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R5
  AST_READY_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_ready) |-> $past(enc_xfer)); // R4
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    enc_hdr_take |=> (!hdr_ready && tx_valid)); // R4

endmodule

// File: rtl/pf_decoder.sv
module pf_decoder
  import pf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic [3:0]        rx_type,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [LEN_W-1:0]  rx_len,
  output logic              done,
  output logic              crc_ok,
  output logic              pid_err
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int LEN_BYTES  = LEN_W / 8;

  dec_st_t           st;
  logic [3:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt;
  logic [15:0]       crc_q;
  logic [7:0]        crc_hi;
  logic              done_q, ok_q, perr_q;

  // named events
  logic             dec_take, dec_covered, dec_pay_last, dec_pkt_end;
  logic [LEN_W-1:0] len_nx;

  assign rx_ready     = (st == D_PAY) ? out_ready : 1'b1;
  assign dec_take     = rx_valid && rx_ready;
  assign out_valid    = (st == D_PAY) && rx_valid;
  assign out_data     = rx_data;
  assign out_last     = out_valid && (cnt == len_q - 1'b1);
  assign dec_pay_last = dec_take && out_last;
  assign dec_covered  = dec_take && (st == D_ADDR || st == D_LEN || st == D_PAY);
  assign dec_pkt_end  = dec_take && (st == D_CRC) && (cnt != '0);
  assign len_nx       = {len_q[LEN_W-9:0], rx_data};

  assign rx_type = kind_q;
  assign rx_addr = addr_q;
  assign rx_len  = len_q;
  assign done    = done_q;
  assign crc_ok  = ok_q;
  assign pid_err = perr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= D_HUNT;
      kind_q <= '0;
      addr_q <= '0;
      len_q  <= '0;
      cnt    <= '0;
      crc_q  <= CRC_SEED;
      crc_hi <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      perr_q <= 1'b0;
      if (dec_covered) crc_q <= crc_step(crc_q, rx_data);
      if (dec_take) begin
        case (st)
          D_HUNT: if (rx_data == MARK_A) st <= D_MK1;
          D_MK1: begin
            if (rx_data == MARK_B)      st <= D_PID;
            else if (rx_data != MARK_A) st <= D_HUNT;
          end
          D_PID: begin
            if (pid_good(rx_data)) begin
              kind_q <= rx_data[7:4];
              crc_q  <= CRC_SEED;
              cnt    <= '0;
              st     <= D_ADDR;
            end else begin
              perr_q <= 1'b1;
              st     <= D_HUNT;
            end
          end
          D_ADDR: begin
            addr_q <= {addr_q[ADDR_W-9:0], rx_data};
            if (cnt == LEN_W'(ADDR_BYTES - 1)) begin st <= D_LEN; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          D_LEN: begin
            len_q <= len_nx;
            if (cnt == LEN_W'(LEN_BYTES - 1)) begin
              cnt <= '0;
              st  <= (len_nx == '0) ? D_CRC : D_PAY;
            end else cnt <= cnt + 1'b1;
          end
          D_PAY: begin
            if (out_last) begin st <= D_CRC; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          D_CRC: begin
            if (cnt == '0) begin
              crc_hi <= rx_data;
              cnt    <= LEN_W'(1);
            end else begin
              done_q <= 1'b1;
              ok_q   <= ({crc_hi, rx_data} == crc_q);
              cnt    <= '0;
              st     <= D_HUNT;
            end
          end
          default: st <= D_HUNT;
        endcase
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pkt_end |=> done); // R9
  AST_PIDERR_REHUNT: assert property (@(posedge clk) disable iff (!rst_n)
    pid_err |-> (st == D_HUNT && !done)); // R7
  AST_LAST_TO_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pay_last |=> (st == D_CRC && !out_valid)); // R8

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [3:0]        hdr_type,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [7:0]        pl_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic [3:0]        rx_type,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [LEN_W-1:0]  rx_len,
  output logic              done,
  output logic              crc_ok,
  output logic              pid_err
);

  pf_encoder #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_enc (
    .clk(clk), .rst_n(rst_n),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_type(hdr_type),
    .hdr_addr(hdr_addr), .hdr_len(hdr_len),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  pf_decoder #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .rx_type(rx_type), .rx_addr(rx_addr), .rx_len(rx_len),
    .done(done), .crc_ok(crc_ok), .pid_err(pid_err)
  );

endmodule

// File: tb/sim_pkt_framer.sv
module sim_pkt_framer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        hdr_valid = 0, hdr_ready;
  logic [3:0]  hdr_type = 0;
  logic [31:0] hdr_addr = 0;
  logic [15:0] hdr_len = 0;
  logic        pl_valid = 0, pl_ready;
  logic [7:0]  pl_data = 0;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ready;
  logic [7:0]  rx_data;
  logic        out_valid, out_ready = 1, out_last;
  logic [7:0]  out_data;
  logic [3:0]  rx_type;
  logic [31:0] rx_addr;
  logic [15:0] rx_len;
  logic        done, crc_ok, pid_err;

  // link mux: loopback from framer or direct injection
  logic       loop_en = 1;
  logic       inj_valid = 0;
  logic [7:0] inj_data = 0;
  assign rx_valid = loop_en ? tx_valid : inj_valid;
  assign rx_data  = loop_en ? tx_data  : inj_data;
  assign tx_ready = loop_en ? rx_ready : 1'b0;

  pkt_framer u0 (.*);

  int runs = 0, fails = 0;
  logic bp_mode = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor
  logic [7:0] txb [0:127];
  logic [7:0] ob  [0:127];
  int txn = 0, on = 0, last_cnt = 0, last_pos = -1, done_cnt = 0, perr_cnt = 0;
  logic done_ok = 0;
  logic clr_mon = 0;
  always @(negedge clk) begin
    if (clr_mon) begin
      txn = 0; on = 0; last_cnt = 0; last_pos = -1; done_cnt = 0; perr_cnt = 0;
    end else begin
      if (tx_valid && tx_ready && txn < 128) begin txb[txn] = tx_data; txn++; end
      if (out_valid && out_ready && on < 128) begin
        if (out_last) begin last_cnt++; last_pos = on; end
        ob[on] = out_data; on++;
      end
      if (done) begin done_cnt++; done_ok = crc_ok; end
      if (pid_err) perr_cnt++;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_mode ? ~out_ready : 1'b1;
    end
  end

  task automatic clear_mon();
    clr_mon = 1; @(negedge clk); clr_mon = 0;
  endtask

  // expected frame built independently
  logic [7:0] expb [0:127];
  int expn = 0;
  function automatic logic [7:0] pbyte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction
  function automatic logic [15:0] ref_crc(input int from, input int upto);
    logic [15:0] c = 16'hFFFF;
    for (int k = from; k < upto; k++) begin
      c = c ^ {expb[k], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction
  task automatic build(input logic [3:0] t, input logic [31:0] a, input logic [15:0] l,
                       input logic [7:0] seed);
    logic [15:0] el, c;
    el = (t == 4'h1) ? 16'd0 : l;
    expb[0] = 8'hAA; expb[1] = 8'h55; expb[2] = {t, ~t};
    for (int k = 0; k < 4; k++) expb[3+k] = a[31-8*k -: 8];
    expb[7] = el[15:8]; expb[8] = el[7:0];
    for (int k = 0; k < int'(el); k++) expb[9+k] = pbyte(seed, k);
    expn = 9 + int'(el);
    c = ref_crc(3, expn);
    expb[expn] = c[15:8]; expb[expn+1] = c[7:0];
    expn += 2;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 400 && done_cnt == 0 && perr_cnt == 0; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic inject(input logic [7:0] b);
    inj_valid = 1; inj_data = b;
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    @(posedge clk); #1;
    inj_valid = 0;
  endtask

  // vectors: {type, bp, addr, len, seed}
  localparam logic [63:0] VEC [6] = '{
    {4'h2, 4'h0, 32'hDEADBEEF, 16'd5,  8'h11},
    {4'h2, 4'h0, 32'h00000000, 16'd0,  8'h00},
    {4'h1, 4'h0, 32'h12345678, 16'd9,  8'h33},
    {4'h2, 4'h1, 32'hFFFFFFFF, 16'd17, 8'hF0},
    {4'h2, 4'h1, 32'hA55AAA55, 16'd3,  8'hAA},
    {4'h2, 4'h0, 32'h00000001, 16'd1,  8'h55}
  };

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(hdr_ready == 1'b1, "R11 hdr_ready", 32'(hdr_ready), 1);
    chk(tx_valid == 1'b0 && out_valid == 1'b0, "R11 valids", 32'({tx_valid, out_valid}), 0);
    chk(done == 1'b0 && pid_err == 1'b0, "R11 strobes", 32'({done, pid_err}), 0);

    foreach (VEC[v]) begin
      logic [3:0] t; logic [31:0] a; logic [15:0] l, el; logic [7:0] s;
      t = VEC[v][63:60]; a = VEC[v][55:24]; l = VEC[v][23:8]; s = VEC[v][7:0];
      el = (t == 4'h1) ? 16'd0 : l;
      build(t, a, l, s);
      clear_mon();
      bp_mode = VEC[v][56];
      @(posedge clk); #1;
      hdr_valid = 1; hdr_type = t; hdr_addr = a; hdr_len = l;
      @(negedge clk);
      while (!hdr_ready) @(negedge clk);
      @(posedge clk); #1;
      hdr_valid = 0;
      @(negedge clk);
      chk(hdr_ready == 1'b0, "R4 busy after header", 32'(hdr_ready), 0);
      for (int i = 0; i < int'(el); i++) begin
        if (i % 3 == 1) begin pl_valid = 0; @(posedge clk); #1; end
        pl_valid = 1; pl_data = pbyte(s, i);
        @(negedge clk);
        while (!pl_ready) @(negedge clk);
        @(posedge clk); #1;
        pl_valid = 0;
      end
      wait_end();
      bp_mode = 0;
      begin
        int bad = 0;
        for (int k = 0; k < expn; k++) if (txb[k] !== expb[k]) bad++;
        chk(txn == expn, "R1 frame length", 32'(txn), 32'(expn));
        chk(bad == 0, "R1 R2 R3 frame bytes", 32'(bad), 0);
        bad = 0;
        for (int k = 0; k < int'(el); k++) if (ob[k] !== pbyte(s, k)) bad++;
        chk(on == int'(el) && bad == 0, "R8 R10 payload out", 32'(on), 32'(el));
      end
      chk(last_cnt == (el != 0 ? 1 : 0) && last_pos == int'(el) - 1, "R8 out_last",
          32'(last_pos), 32'(int'(el) - 1));
      chk(rx_addr == a && rx_len == el && rx_type == t, "R8 header fields", rx_addr, a);
      chk(done_cnt == 1 && done_ok == 1'b1, "R9 done crc_ok", 32'({done_cnt[3:0], done_ok}), 32'h11);
      chk(hdr_ready == 1'b1, "R4 idle after frame", 32'(hdr_ready), 1);
    end

    // direct injection
    loop_en = 0;
    // R7 bad check nibble
    clear_mon();
    inject(8'hAA); inject(8'h55); inject(8'h2E);
    inject(8'h11); inject(8'h22); inject(8'h33); inject(8'h44);
    repeat (2) @(negedge clk);
    chk(perr_cnt == 1 && done_cnt == 0 && on == 0, "R7 bad check nibble", 32'(perr_cnt), 1);
    // R7 unknown type with consistent nibbles
    clear_mon();
    inject(8'hAA); inject(8'h55); inject(8'h3C); inject(8'h00);
    repeat (2) @(negedge clk);
    chk(perr_cnt == 1 && done_cnt == 0, "R7 unknown type", 32'(perr_cnt), 1);
    // R6 leading junk and repeated marker byte
    build(4'h2, 32'hCAFE0001, 16'd4, 8'h5A);
    clear_mon();
    inject(8'h00); inject(8'hAA);
    for (int k = 0; k < expn; k++) inject(expb[k]);
    wait_end();
    chk(done_cnt == 1 && done_ok == 1'b1 && on == 4, "R6 resync", 32'(on), 4);
    // R3 corrupted address byte detected
    build(4'h2, 32'h01020304, 16'd2, 8'h10);
    expb[4] = expb[4] ^ 8'h80;
    clear_mon();
    for (int k = 0; k < expn; k++) inject(expb[k]);
    wait_end();
    chk(done_cnt == 1 && done_ok == 1'b0, "R3 address covered", 32'(done_ok), 0);
    // R9 corrupted CRC byte
    build(4'h1, 32'h0BADF00D, 16'd0, 8'h00);
    expb[expn-1] = expb[expn-1] ^ 8'h01;
    clear_mon();
    for (int k = 0; k < expn; k++) inject(expb[k]);
    wait_end();
    chk(done_cnt == 1 && done_ok == 1'b0, "R9 bad crc", 32'(done_ok), 0);
    // R10 stalled payload output holds rx_ready low
    build(4'h2, 32'h00000010, 16'd2, 8'h01);
    clear_mon();
    bp_mode = 0;
    for (int k = 0; k < 9; k++) inject(expb[k]);
    force_stall();
    for (int k = 9; k < expn; k++) inject(expb[k]);
    wait_end();
    chk(done_cnt == 1 && done_ok == 1'b1 && on == 2, "R10 stall then resume", 32'(on), 2);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  task automatic force_stall();
    bp_mode = 1;
    @(posedge clk); #2;
    if (out_ready) begin @(posedge clk); #2; end
    inj_valid = 1; inj_data = expb[9];
    @(negedge clk);
    chk(out_ready == 1'b0 && rx_ready == 1'b0, "R10 rx_ready follows out_ready",
        32'(rx_ready), 0);
    inj_valid = 0;
    bp_mode = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    runs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule